// File: doc/BRIEF.md
# Multi-Warp Fetch Scheduler

This block sits at the front of a SIMT core that runs several warps. Each cycle it chooses one warp to hand to instruction fetch. A warp can be chosen when it is active and not locked. It presents the warp's index, program counter and thread mask on a valid/ready interface. When fetch accepts a warp, the scheduler locks that warp and advances its program counter by one 4-byte instruction. The warp stays locked until the decode stage releases it, so each warp has at most one instruction in the front end.

Run-time control comes in through four inputs:

- A spawn command wakes up further warps at a common start address.
- An exit request stops every warp and records that the core has finished.
- A resume pulse unlocks every warp at once.
- A decode release unlocks a single warp. A release whose hold flag is set leaves that warp locked.

The warp count can be set from 2 to 16. The thread count and address width are also parameters.

Top module: `warp_sched`

## Requirements
- R1: After reset, only warp 0 is active and only thread 0 of warp 0 is enabled (mask bit 0 = thread 0). Every lock is clear, every program counter equals RESET_PC, and `exited` is low.
- R2: `fetch_valid` is high exactly when some warp is active and unlocked. `fetch_wid` is then the lowest-numbered such warp, and `fetch_pc` and `fetch_tmask` are that warp's values.
- R3: While `fetch_valid` is high and `fetch_ready` is low, the offered warp gets no lock and its program counter does not change.
- R4: A cycle with both `fetch_valid` and `fetch_ready` high locks the offered warp from the next cycle on and adds 4 to its program counter.
- R5: A release with `rel_hold` low unlocks warp `rel_wid`. A release with `rel_hold` high has no effect.
- R6: A `resume` pulse unlocks every warp. A warp accepted in the same cycle still ends up locked.
- R7: A spawn with count N activates warps 1 through min(N, NUM_WARPS)-1. Each of those warps gets `spawn_pc` and a thread mask with only thread 0 enabled. Warp 0 is never changed, and N of 0 or 1 has no effect.
- R8: `exit_req` clears the whole active mask in the next cycle and sets `exited`. `exited` stays high until reset.
- R9: When `exit_req` and a spawn arrive in the same cycle, the exit wins and no warp is left active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | output | 1 | A warp is offered to fetch |
| fetch_ready | input | 1 | Fetch accepts the offered warp |
| fetch_wid | output | $clog2(NUM_WARPS) | Index of the offered warp |
| fetch_pc | output | PC_W | Program counter of the offered warp |
| fetch_tmask | output | NUM_THREADS | Thread mask of the offered warp |
| rel_valid | input | 1 | Decode release strobe |
| rel_wid | input | $clog2(NUM_WARPS) | Warp being released |
| rel_hold | input | 1 | Released instruction keeps its warp locked |
| spawn_valid | input | 1 | Spawn command strobe |
| spawn_count | input | CNT_W | Requested total warp count |
| spawn_pc | input | PC_W | Start address for spawned warps |
| exit_req | input | 1 | Stop all warps |
| resume | input | 1 | Unlock all warps |
| active_mask | output | NUM_WARPS | Active warp set |
| exited | output | 1 | Sticky exit flag |

## Verification
A lock bit that stays set when it should clear shows up as a warp that drops out of the fetch offer. A lock bit that clears when it should stay set shows up as the same warp being offered again in the cycle right after it was accepted. Either error is visible one clock after the triggering event. A wrong program counter or thread mask stays hidden until the next time that warp is offered, which can be many cycles later. For that reason the directed sequences drive each spawned warp through the fetch interface. Errors in the active set appear on `active_mask` after one clock.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;
  // Bytes per instruction; the program counter advances by this on accept.
  localparam int unsigned INSN_BYTES = 4;

  // Per-warp context update selected each cycle.
  typedef enum logic [1:0] {
    CTX_KEEP = 2'd0,
    CTX_STEP = 2'd1,
    CTX_LOAD = 2'd2
  } ctx_op_e;
endpackage

// File: rtl/wsched_pick.sv
`timescale 1ns/1ps
// Lowest-index-first priority selector.
module wsched_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wsched_ctx.sv
`timescale 1ns/1ps
// Per-warp program counter and thread mask storage.
module wsched_ctx
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned CNT_W       = 8,
  parameter logic [PC_W-1:0] RESET_PC = 'h1000,
  localparam int unsigned WID_W      = $clog2(NUM_WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_en,
  input  logic [WID_W-1:0]       adv_wid,
  input  logic                   spawn_en,
  input  logic [CNT_W-1:0]       spawn_count,
  input  logic [PC_W-1:0]        spawn_pc,
  input  logic [WID_W-1:0]       sel_wid,
  output logic [PC_W-1:0]        sel_pc,
  output logic [NUM_THREADS-1:0] sel_tmask
);
  localparam logic [NUM_THREADS-1:0] THR_FIRST = NUM_THREADS'(1);

  logic [PC_W-1:0]        pc_arr [NUM_WARPS];
  logic [NUM_THREADS-1:0] tm_arr [NUM_WARPS];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    localparam bit SPAWNABLE = (g != 0);
    ctx_op_e                op;
    logic                   ctx_en;
    logic [PC_W-1:0]        pc_q, pc_d;
    logic [NUM_THREADS-1:0] tm_q, tm_d;

    always_comb begin
      op = CTX_KEEP;
      if (adv_en && (adv_wid == WID_W'(g))) op = CTX_STEP;
      if (SPAWNABLE && spawn_en && (spawn_count > CNT_W'(g))) op = CTX_LOAD;
    end

    always_comb begin
      pc_d   = pc_q;
      tm_d   = tm_q;
      ctx_en = 1'b0;
      case (op)
        CTX_STEP: begin
          pc_d   = pc_q + PC_W'(INSN_BYTES);
          ctx_en = 1'b1;
        end
        CTX_LOAD: begin
          pc_d   = spawn_pc;
          tm_d   = THR_FIRST;
          ctx_en = 1'b1;
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q <= RESET_PC;
        tm_q <= SPAWNABLE ? '0 : THR_FIRST;
      end else if (ctx_en) begin
        pc_q <= pc_d;
        tm_q <= tm_d;
      end
    end

    assign pc_arr[g] = pc_q;
    assign tm_arr[g] = tm_q;
  end

  assign sel_pc    = pc_arr[sel_wid];
  assign sel_tmask = tm_arr[sel_wid];
endmodule

// File: rtl/warp_sched.sv
`timescale 1ns/1ps
module warp_sched #(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned CNT_W       = 8,
  parameter logic [PC_W-1:0] RESET_PC = 'h1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         fetch_valid,
  input  logic                         fetch_ready,
  output logic [$clog2(NUM_WARPS)-1:0] fetch_wid,
  output logic [PC_W-1:0]              fetch_pc,
  output logic [NUM_THREADS-1:0]       fetch_tmask,
  input  logic                         rel_valid,
  input  logic [$clog2(NUM_WARPS)-1:0] rel_wid,
  input  logic                         rel_hold,
  input  logic                         spawn_valid,
  input  logic [CNT_W-1:0]             spawn_count,
  input  logic [PC_W-1:0]              spawn_pc,
  input  logic                         exit_req,
  input  logic                         resume,
  output logic [NUM_WARPS-1:0]         active_mask,
  output logic                         exited
);
  localparam int unsigned WID_W = $clog2(NUM_WARPS);
  localparam logic [NUM_WARPS-1:0] WARP0_ONLY = NUM_WARPS'(1);

  logic [NUM_WARPS-1:0] active_q, active_d;
  logic [NUM_WARPS-1:0] stall_q, stall_d;
  logic                 exited_q;
  logic                 active_en, stall_en;
  logic [NUM_WARPS-1:0] eligible;
  logic                 fire;
  logic [WID_W-1:0]     pick_wid;
  logic                 pick_found;

  assign eligible = active_q & ~stall_q;

  wsched_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick (
    .req   (eligible),
    .found (pick_found),
    .idx   (pick_wid)
  );

  assign fetch_valid = pick_found;
  assign fetch_wid   = pick_wid;
  assign fire        = pick_found & fetch_ready;

  wsched_ctx #(
    .NUM_WARPS   (NUM_WARPS),
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .CNT_W       (CNT_W),
    .RESET_PC    (RESET_PC)
  ) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_en      (fire),
    .adv_wid     (pick_wid),
    .spawn_en    (spawn_valid),
    .spawn_count (spawn_count),
    .spawn_pc    (spawn_pc),
    .sel_wid     (pick_wid),
    .sel_pc      (fetch_pc),
    .sel_tmask   (fetch_tmask)
  );

  // Lock mask: single release, then bulk resume, then the accepted warp.
  always_comb begin
    stall_en = rel_valid | resume | fire;
    stall_d  = stall_q;
    if (rel_valid && !rel_hold) stall_d[rel_wid] = 1'b0;
    if (resume)                 stall_d          = '0;
    if (fire)                   stall_d[pick_wid] = 1'b1;
  end

  // Active mask: spawn adds warps above 0, exit overrides everything.
  always_comb begin
    active_en = spawn_valid | exit_req;
    active_d  = active_q;
    if (spawn_valid) begin
      for (int i = 1; i < NUM_WARPS; i++) begin
        if (spawn_count > CNT_W'(i)) active_d[i] = 1'b1;
      end
    end
    if (exit_req) active_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= WARP0_ONLY;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
    end else if (stall_en) begin
      stall_q <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exited_q <= 1'b0;
    end else if (exit_req) begin
      exited_q <= 1'b1;
    end
  end

  assign active_mask = active_q;
  assign exited      = exited_q;
endmodule

// File: rtl/wsched_chk.sv
`timescale 1ns/1ps
module wsched_chk #(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned PC_W      = 32,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic                 fetch_ready,
  input logic [WID_W-1:0]     fetch_wid,
  input logic [PC_W-1:0]      fetch_pc,
  input logic                 rel_valid,
  input logic                 spawn_valid,
  input logic                 exit_req,
  input logic                 resume,
  input logic [NUM_WARPS-1:0] active_mask,
  input logic [NUM_WARPS-1:0] stall_q,
  input logic                 exited
);
  logic [NUM_WARPS-1:0] below_mask;
  assign below_mask = ~({NUM_WARPS{1'b1}} << fetch_wid);

  // R2
  offered_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (active_mask[fetch_wid] && !stall_q[fetch_wid]));

  // R2
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ((active_mask & ~stall_q & below_mask) == '0));

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !spawn_valid && !exit_req && !rel_valid && !resume)
    |=> (fetch_valid && $stable(fetch_wid) && $stable(fetch_pc)));

  // R4
  accept_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> stall_q[$past(fetch_wid)]);

  // R6
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !fetch_ready) |=> (stall_q == '0));

  // R8
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> (active_mask == '0 && exited));

  // R8
  exit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exited |=> exited);
endmodule

bind warp_sched wsched_chk #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_wid   (fetch_wid),
  .fetch_pc    (fetch_pc),
  .rel_valid   (rel_valid),
  .spawn_valid (spawn_valid),
  .exit_req    (exit_req),
  .resume      (resume),
  .active_mask (active_mask),
  .stall_q     (stall_q),
  .exited      (exited)
);

// File: tb/sim_warp_sched.sv
`timescale 1ns/1ps
module sim_warp_sched;
  localparam int unsigned NW = 4;
  localparam int unsigned NT = 4;
  localparam int unsigned PW = 32;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid, fetch_ready;
  logic [1:0]    fetch_wid;
  logic [PW-1:0] fetch_pc;
  logic [NT-1:0] fetch_tmask;
  logic          rel_valid, rel_hold;
  logic [1:0]    rel_wid;
  logic          spawn_valid;
  logic [CW-1:0] spawn_count;
  logic [PW-1:0] spawn_pc;
  logic          exit_req, resume;
  logic [NW-1:0] active_mask;
  logic          exited;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  warp_sched #(.NUM_WARPS(NW), .NUM_THREADS(NT), .PC_W(PW), .CNT_W(CW),
               .RESET_PC(32'h1000)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_wid(fetch_wid),
    .fetch_pc(fetch_pc), .fetch_tmask(fetch_tmask),
    .rel_valid(rel_valid), .rel_wid(rel_wid), .rel_hold(rel_hold),
    .spawn_valid(spawn_valid), .spawn_count(spawn_count), .spawn_pc(spawn_pc),
    .exit_req(exit_req), .resume(resume),
    .active_mask(active_mask), .exited(exited)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_ready = 1'b0; rel_valid = 1'b0; rel_wid = '0; rel_hold = 1'b0;
    spawn_valid = 1'b0; spawn_count = '0; spawn_pc = '0;
    exit_req = 1'b0; resume = 1'b0;
  endtask

  // Let one rising edge pass, then clear all strobes at the falling edge.
  task automatic cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic accept_one();
    fetch_ready = 1'b1;
    cyc();
  endtask

  task automatic release_warp(input logic [1:0] w, input logic hold);
    rel_valid = 1'b1; rel_wid = w; rel_hold = hold;
    cyc();
  endtask

  task automatic spawn(input logic [CW-1:0] n, input logic [PW-1:0] pc);
    spawn_valid = 1'b1; spawn_count = n; spawn_pc = pc;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 active", active_mask, 4'b0001);
    chk("R1 exited", exited, 1'b0);
    chk("R1 valid", fetch_valid, 1'b1);
    chk("R1 wid", fetch_wid, 0);
    chk("R1 pc", fetch_pc, 32'h1000);
    chk("R1 tmask", fetch_tmask, 4'b0001);
  endtask

  task automatic t_hold();
    cyc(); cyc();
    chk("R3 valid held", fetch_valid, 1'b1);
    chk("R3 wid held", fetch_wid, 0);
    chk("R3 pc held", fetch_pc, 32'h1000);
  endtask

  task automatic t_accept_release();
    accept_one();
    chk("R4 locked after accept", fetch_valid, 1'b0);
    chk("R2 none eligible", active_mask, 4'b0001);
    release_warp(2'd0, 1'b1);
    chk("R5 hold flag keeps lock", fetch_valid, 1'b0);
    release_warp(2'd0, 1'b0);
    chk("R5 release unlocks", fetch_valid, 1'b1);
    chk("R4 pc advanced", fetch_pc, 32'h1004);
  endtask

  task automatic t_spawn();
    spawn(8'd1, 32'h5000);
    chk("R7 count 1 no effect", active_mask, 4'b0001);
    spawn(8'd0, 32'h5000);
    chk("R7 count 0 no effect", active_mask, 4'b0001);
    spawn(8'd3, 32'h2000);
    chk("R7 spawn 3 active", active_mask, 4'b0111);
    chk("R7 warp0 untouched pc", fetch_pc, 32'h1004);
    chk("R2 warp0 first", fetch_wid, 0);
    accept_one();
    chk("R2 next lowest", fetch_wid, 1);
    chk("R7 spawned pc", fetch_pc, 32'h2000);
    chk("R7 spawned tmask", fetch_tmask, 4'b0001);
    accept_one();
    chk("R2 warp2 offered", fetch_wid, 2);
    chk("R7 warp2 pc", fetch_pc, 32'h2000);
    accept_one();
    chk("R2 all locked", fetch_valid, 1'b0);
  endtask

  task automatic t_resume();
    resume = 1'b1;
    cyc();
    chk("R6 resume valid", fetch_valid, 1'b1);
    chk("R6 resume wid", fetch_wid, 0);
    chk("R4 warp0 pc", fetch_pc, 32'h1008);
    accept_one();
    chk("R4 warp1 pc stepped", fetch_pc, 32'h2004);
    chk("R2 warp1 offered", fetch_wid, 1);
  endtask

  task automatic t_spawn_clip();
    spawn(8'd9, 32'h3000);
    chk("R7 clipped to all warps", active_mask, 4'b1111);
    chk("R7 warp1 reloaded", fetch_pc, 32'h3000);
    release_warp(2'd0, 1'b0);
    chk("R5 warp0 back first", fetch_wid, 0);
    chk("R4 warp0 pc", fetch_pc, 32'h100C);
    accept_one(); accept_one(); accept_one();
    chk("R7 warp3 offered", fetch_wid, 3);
    chk("R7 warp3 pc", fetch_pc, 32'h3000);
    chk("R7 warp3 tmask", fetch_tmask, 4'b0001);
  endtask

  task automatic t_exit();
    exit_req = 1'b1; spawn_valid = 1'b1; spawn_count = 8'd4; spawn_pc = 32'h7000;
    cyc();
    chk("R9 exit beats spawn", active_mask, 4'b0000);
    chk("R8 exited set", exited, 1'b1);
    chk("R8 nothing offered", fetch_valid, 1'b0);
    resume = 1'b1;
    cyc(); cyc();
    chk("R8 exited sticky", exited, 1'b1);
    chk("R8 still none active", fetch_valid, 1'b0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_accept_release();
    t_spawn();
    t_resume();
    t_spawn_clip();
    t_exit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule